// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block collects the interrupt causes of a 16450/16550-compatible serial port, gates each one with its enable bit, and picks the single most urgent one. It reports that cause as a read-only identification byte and drives an interrupt request line. It keeps its own pending flags for causes that are edge events:

- line errors;
- modem-line changes;
- transmitter-empty.

Receive data availability is taken as a level from the receive path.

The block also contains a receive timeout detector. While the receive FIFO holds data, the detector counts character-time ticks. It raises a cause of its own once four character times pass with no push into and no read from the FIFO. The block also applies the clearing rules: each cause is removed by the register access that services it. The transmitter-empty cause has an extra rule: it is also dropped when the identification byte is read while that cause is the one being shown.

The surrounding port logic feeds in the following inputs and presents `isr` on reads of the identification address:

- event pulses;
- receive levels;
- FIFO occupancy;
- register access strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: `isr[0]` is 0 whenever at least one enabled cause is pending and 1 otherwise; `irq` is always the inverse of `isr[0]`.
- R2: `isr[5:4]` always read 0; `isr[7:6]` both read 1 when `fifo_en` is 1 and both read 0 when it is 0.
- R3: A pulse on any bit of `line_ev` makes a line-status cause pending. `line_ev` bit 0 is overrun, bit 1 parity, bit 2 framing and bit 3 break. This cause has top priority and shows as `isr[3:1]` = 011.
- R4: Receive data is second priority and shows as 010. With `fifo_en` = 0 it follows `rx_ready`. With `fifo_en` = 1 it follows `rx_trig` and ignores `rx_ready`. It is a level with no stored state, and it outranks the timeout.
- R5: With `fifo_en` = 1, the timeout cause shows as 110 once `rx_count` is non-zero and four `char_tick` pulses have been counted since the last `rx_push` or `rd_data`. It clears on `rd_data`. With `fifo_en` = 0, `isr[3]` is always 0 and the timeout never appears.
- R6: The line-status cause clears on `rd_lsr`. The modem cause clears on `rd_msr`.
- R7: A `txe_ev` pulse makes the transmitter-empty cause pending. It is third priority, shows as 001, and clears on `wr_thr`.
- R8: `rd_isr` clears transmitter-empty only if 001 is the code shown in that same cycle. A set pulse in the same cycle as any clearing action leaves the cause pending.
- R9: A pulse on any bit of `modem_ev` makes the modem cause pending. The bits are delta CTS, delta DSR, ring trailing edge and delta DCD, at bits 0 to 3. This cause is fourth priority and shows as 000.
- R10: Enable bits in `ien` are bit 0 receive data and timeout, bit 1 transmitter-empty, bit 2 line status and bit 3 modem. A disabled cause is still recorded and appears as soon as its enable is set.
- R11: The timeout count restarts on each `rx_push` or `rd_data`. It is held at zero while `rx_count` is 0 or `fifo_en` is 0.
- R12: Reset clears all pending state, so `isr` reads 0x01 after reset with `fifo_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode select (1 = 16550 mode) |
| ien | input | 4 | Per-cause enables |
| line_ev | input | 4 | Line error event pulses (overrun, parity, framing, break) |
| rx_ready | input | 1 | Receive data present (used with FIFOs off) |
| rx_trig | input | 1 | Receive FIFO at or above trigger level |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_push | input | 1 | A character was written into the receive FIFO |
| txe_ev | input | 1 | Transmit holding register became empty |
| modem_ev | input | 4 | Modem change pulses (dCTS, dDSR, ring trailing edge, dDCD) |
| rd_data | input | 1 | Read strobe of the receive data register |
| rd_lsr | input | 1 | Read strobe of the line status register |
| rd_msr | input | 1 | Read strobe of the modem status register |
| rd_isr | input | 1 | Read strobe of the identification byte |
| wr_thr | input | 1 | Write strobe of the transmit holding register |
| char_tick | input | 1 | One pulse per character time |
| isr | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The checker enforces three relations on every cycle:

- the fixed upper bits follow the FIFO mode;
- `irq` mirrors `isr[0]`;
- `isr[3]` stays low with FIFOs off.

It also checks that a line event is shown on the next cycle, and that the servicing accesses (line-status read, modem read, transmit write, data read) remove their cause on the cycle after.

Only the bench scenarios can show the remaining behaviour:

- the full priority ordering between all pending causes;
- the conditional clear of transmitter-empty on an identification read;
- the set-over-clear rule;
- the four-tick timeout window with its restarts on push, read, empty FIFO and disabled FIFOs.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        ID_LINE    = 3'b011,
        ID_RXDATA  = 3'b010,
        ID_RXTMO   = 3'b110,
        ID_TXEMPTY = 3'b001,
        ID_MODEM   = 3'b000
    } irq_id_e;

    typedef struct packed {
        logic line;
        logic txe;
        logic modem;
    } pend_t;

    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int N_EN     = 4;

endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
    import uart_irq_pkg::*;
#(
    parameter int N_LINE  = 4,
    parameter int N_MODEM = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINE-1:0]  line_ev,
    input  logic [N_MODEM-1:0] modem_ev,
    input  logic               txe_ev,
    input  logic               rd_lsr,
    input  logic               rd_msr,
    input  logic               wr_thr,
    input  logic               txe_ack,
    output pend_t              pend_q
);

    pend_t pend_d;

    always_comb begin
        pend_d = pend_q;
        // clears first, then sets, so a same-cycle event survives
        if (rd_lsr)            pend_d.line  = 1'b0;
        if (rd_msr)            pend_d.modem = 1'b0;
        if (wr_thr || txe_ack) pend_d.txe   = 1'b0;
        if (|line_ev)          pend_d.line  = 1'b1;
        if (|modem_ev)         pend_d.modem = 1'b1;
        if (txe_ev)            pend_d.txe   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
    parameter int TMO_CHARS = 4,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rd_data,
    input  logic             char_tick,
    output logic             tmo
);

    localparam int TW = $clog2(TMO_CHARS + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TMO_CHARS);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmo_st_t;

    tmo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!fifo_en || rx_count == '0 || rx_push || rd_data)
            st_d.cnt = '0;
        else if (char_tick && st_q.cnt != LIMIT)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmo = (st_q.cnt == LIMIT);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic    line,
    input  logic    rxdat,
    input  logic    rxtmo,
    input  logic    txe,
    input  logic    modem,
    output logic    any,
    output irq_id_e id
);

    always_comb begin
        any = 1'b1;
        id  = ID_MODEM;
        if      (line)  id = ID_LINE;
        else if (rxdat) id = ID_RXDATA;
        else if (rxtmo) id = ID_RXTMO;
        else if (txe)   id = ID_TXEMPTY;
        else if (modem) id = ID_MODEM;
        else            any = 1'b0;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TMO_CHARS  = 4,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [3:0]       ien,
    input  logic [3:0]       line_ev,
    input  logic             rx_ready,
    input  logic             rx_trig,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             txe_ev,
    input  logic [3:0]       modem_ev,
    input  logic             rd_data,
    input  logic             rd_lsr,
    input  logic             rd_msr,
    input  logic             rd_isr,
    input  logic             wr_thr,
    input  logic             char_tick,
    output logic [7:0]       isr,
    output logic             irq
);

    pend_t   pend_q;
    logic    tmo;
    logic    any;
    irq_id_e id;
    logic    txe_ack;
    logic    rx_src;
    logic    m_line, m_rx, m_tmo, m_txe, m_modem;

    assign rx_src  = fifo_en ? rx_trig : rx_ready;
    assign m_line  = pend_q.line  & ien[EN_LINE];
    assign m_rx    = rx_src       & ien[EN_RX];
    assign m_tmo   = tmo & fifo_en & ien[EN_RX];
    assign m_txe   = pend_q.txe   & ien[EN_TX];
    assign m_modem = pend_q.modem & ien[EN_MODEM];

    // transmit-empty is acknowledged only when it is the code being read
    assign txe_ack = rd_isr && any && (id == ID_TXEMPTY);

    uart_irq_flags #(.N_LINE(4), .N_MODEM(4)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_ev  (line_ev),
        .modem_ev (modem_ev),
        .txe_ev   (txe_ev),
        .rd_lsr   (rd_lsr),
        .rd_msr   (rd_msr),
        .wr_thr   (wr_thr),
        .txe_ack  (txe_ack),
        .pend_q   (pend_q)
    );

    uart_irq_tmo #(.TMO_CHARS(TMO_CHARS), .CNT_W(CNT_W)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .rx_count  (rx_count),
        .rx_push   (rx_push),
        .rd_data   (rd_data),
        .char_tick (char_tick),
        .tmo       (tmo)
    );

    uart_irq_prio u_prio (
        .line  (m_line),
        .rxdat (m_rx),
        .rxtmo (m_tmo),
        .txe   (m_txe),
        .modem (m_modem),
        .any   (any),
        .id    (id)
    );

    always_comb begin
        isr      = '0;
        isr[7:6] = {2{fifo_en}};
        isr[3:1] = id;
        isr[3]   = id[2] & fifo_en;
        isr[0]   = ~any;
    end

    assign irq = any;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic [3:0]       ien,
    input logic [3:0]       line_ev,
    input logic             rx_ready,
    input logic             rx_trig,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_push,
    input logic             txe_ev,
    input logic [3:0]       modem_ev,
    input logic             rd_data,
    input logic             rd_lsr,
    input logic             rd_msr,
    input logic             rd_isr,
    input logic             wr_thr,
    input logic             char_tick,
    input logic [7:0]       isr,
    input logic             irq
);

    AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !isr[0]); // R1

    AST_UPPER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        isr[5:4] == 2'b00 && isr[7:6] == {2{fifo_en}}); // R2

    AST_LINE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_ev && ien[2]) |=> (!ien[2] || isr[3:0] == 4'b0110)); // R3

    AST_NO_TMO_450: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !isr[3]); // R5

    AST_TMO_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data |=> isr[3:0] != 4'b1100); // R5

    AST_LSR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !(|line_ev)) |=> isr[3:0] != 4'b0110); // R6

    AST_MSR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msr && !(|modem_ev)) |=> isr[3:0] != 4'b0000); // R6

    AST_THR_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thr && !txe_ev) |=> isr[3:0] != 4'b0010); // R7

    logic unused_ok;
    assign unused_ok = ^{rx_ready, rx_trig, rx_count, rx_push, rd_isr, char_tick};

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_en = 1'b0;
    logic [3:0]       ien = 4'hF;
    logic [3:0]       line_ev = '0;
    logic             rx_ready = 1'b0;
    logic             rx_trig = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic             rx_push = 1'b0;
    logic             txe_ev = 1'b0;
    logic [3:0]       modem_ev = '0;
    logic             rd_data = 1'b0;
    logic             rd_lsr = 1'b0;
    logic             rd_msr = 1'b0;
    logic             rd_isr = 1'b0;
    logic             wr_thr = 1'b0;
    logic             char_tick = 1'b0;
    logic [7:0]       isr;
    logic             irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ien(ien),
        .line_ev(line_ev), .rx_ready(rx_ready), .rx_trig(rx_trig),
        .rx_count(rx_count), .rx_push(rx_push), .txe_ev(txe_ev),
        .modem_ev(modem_ev), .rd_data(rd_data), .rd_lsr(rd_lsr),
        .rd_msr(rd_msr), .rd_isr(rd_isr), .wr_thr(wr_thr),
        .char_tick(char_tick), .isr(isr), .irq(irq)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       fe;
        logic [3:0] ien;
        logic [3:0] lev;
        logic [3:0] mev;
        logic       rdy;
        logic       trig;
        logic       txe;
        logic       rdl;
        logic       rdm;
        logic       rdi;
        logic       wrt;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{4'd7,  1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02}, // R7 set
        '{4'd9,  1'b0, 4'hF, 4'h0, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02}, // R9 below R7
        '{4'd3,  1'b0, 4'hF, 4'h1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06}, // R3 overrun
        '{4'd3,  1'b0, 4'hF, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06}, // R3 over data
        '{4'd6,  1'b0, 4'hF, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h04}, // R6 R4
        '{4'd4,  1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02}, // R4 level
        '{4'd8,  1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00}, // R8 R9
        '{4'd6,  1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01}, // R6 msr
        '{4'd7,  1'b0, 4'hF, 4'h0, 4'h2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02}, // R7
        '{4'd8,  1'b0, 4'hF, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h04}, // R8 not shown
        '{4'd8,  1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02}, // R8 kept
        '{4'd7,  1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00}, // R7 write
        '{4'd6,  1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01}, // R6
        '{4'd8,  1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h02}, // R8 set wins
        '{4'd8,  1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01}, // R8 read clr
        '{4'd10, 1'b0, 4'hD, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01}, // R10 masked
        '{4'd10, 1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02}, // R10 unmask
        '{4'd7,  1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01}, // R7
        '{4'd10, 1'b0, 4'hB, 4'h8, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01}, // R10 break
        '{4'd10, 1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06}, // R10
        '{4'd6,  1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01}, // R6 lsr
        '{4'd2,  1'b1, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC1}, // R2
        '{4'd4,  1'b1, 4'hF, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC1}, // R4 rdy off
        '{4'd4,  1'b1, 4'hF, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC4}, // R4 trig
        '{4'd3,  1'b1, 4'hF, 4'h4, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC6}, // R3 framing
        '{4'd6,  1'b1, 4'hF, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC4}, // R6
        '{4'd10, 1'b1, 4'hE, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC1}, // R10 rx off
        '{4'd9,  1'b1, 4'hF, 4'h0, 4'h8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC0}, // R9 dcd
        '{4'd6,  1'b1, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC1}, // R6
        '{4'd2,  1'b0, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01}  // R2 R1
    };

    task automatic clk1();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic chk(input string req, input logic [7:0] exp);
        checks++;
        if (isr !== exp || irq !== ~exp[0]) begin
            failures++;
            $display("FAIL %s: isr=%02h irq=%b expected isr=%02h irq=%b",
                     req, isr, irq, exp, ~exp[0]);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            char_tick = 1'b1;
            clk1();
            char_tick = 1'b0;
        end
    endtask

    task automatic pulse_push();
        rx_push = 1'b1; clk1(); rx_push = 1'b0;
    endtask

    task automatic pulse_rd();
        rd_data = 1'b1; clk1(); rd_data = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD*2 + 1);
        chk("R12 reset", 8'h01);
        rst_n = 1'b1;
        clk1();
        chk("R12 after release", 8'h01);

        for (int i = 0; i < NV; i++) begin
            fifo_en  = VEC[i].fe;   ien      = VEC[i].ien;
            line_ev  = VEC[i].lev;  modem_ev = VEC[i].mev;
            rx_ready = VEC[i].rdy;  rx_trig  = VEC[i].trig;
            txe_ev   = VEC[i].txe;  rd_lsr   = VEC[i].rdl;
            rd_msr   = VEC[i].rdm;  rd_isr   = VEC[i].rdi;
            wr_thr   = VEC[i].wrt;
            clk1();
            line_ev = '0; modem_ev = '0; txe_ev = 1'b0;
            rd_lsr = 1'b0; rd_msr = 1'b0; rd_isr = 1'b0; wr_thr = 1'b0;
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
        end
        rx_ready = 1'b0; rx_trig = 1'b0; ien = 4'hF;

        // timeout window
        fifo_en = 1'b1; rx_count = 5'd3;
        pulse_push();
        tick(3);  chk("R11 three ticks", 8'hC1);
        tick(1);  chk("R5 fourth tick", 8'hCC);
        pulse_rd(); chk("R5 data read clears", 8'hC1);
        tick(2); pulse_push(); tick(3);
        chk("R11 push restarts", 8'hC1);
        tick(1);  chk("R5 after restart", 8'hCC);
        rx_trig = 1'b1; clk1(); chk("R4 data above timeout", 8'hC4);
        rx_trig = 1'b0; clk1(); chk("R5 timeout remains", 8'hCC);
        rx_count = '0; clk1(); chk("R11 empty stops", 8'hC1);
        tick(5);  chk("R11 empty no count", 8'hC1);
        fifo_en = 1'b0; rx_count = 5'd3;
        tick(5);  chk("R5 16450 mode", 8'h01);
        fifo_en = 1'b1; clk1();
        tick(3);  chk("R11 held while disabled", 8'hC1);
        tick(1);  chk("R5 after enable", 8'hCC);

        // reset clears pending state
        fifo_en = 1'b0; rx_count = '0;
        txe_ev = 1'b1; line_ev = 4'h2; clk1();
        txe_ev = 1'b0; line_ev = '0;
        chk("R3 parity", 8'h06);
        rst_n = 1'b0; #1;
        chk("R12 reset mid-run", 8'h01);
        clk1(); rst_n = 1'b1; clk1();
        chk("R12 no stale flags", 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule